// File: doc/BRIEF.md
# Strobe-Timed Static Memory with Latched Selects

This block is a 256-word by 4-bit static memory. Its cycles are framed by an active-low cycle strobe instead of a free-running clock. A fast system clock samples every control input, address bit and data bit through a short synchronising pipeline, and the block detects the strobe's transitions from those samples. When the strobe falls, the block captures the address and a secondary bank select. For the rest of that cycle the address and bank inputs can wander without effect. The bank select works as a high-order address bit: the block takes part in a cycle only if the bank select was low when the cycle began.

A write is level-sensitive. It is open while the strobe, the write control and the primary select are all low in a cycle that began with the bank select low. While the window is open, the addressed word follows the data input on every clock, so the last value present before the window closes is the one that stays. The window closes at the first rise of the strobe, the write control or the primary select.

Read data appears a fixed number of clocks after the cycle begins. When the strobe rises, the read data is frozen and held until the next cycle. The block gives a single output-enable flag for an external three-state driver. The flag is low whenever the write control is low, so the data input and the data output can share one bus. The flag is also low whenever either select is high. During a cycle the flag uses the captured bank select. Between cycles it uses the live bank select pin.

The controller runs a four-state machine:
- IDLE (between cycles).
- WAIT (a selected cycle whose access latency is still counting).
- VALID (a selected cycle with read data valid).
- DESEL (a cycle that began with the bank select high).

The transitions are:
- IDLE→WAIT on a strobe fall with the bank select low.
- IDLE→DESEL on a strobe fall with the bank select high.
- WAIT→VALID when the latency count reaches zero.
- WAIT, VALID or DESEL →IDLE whenever the synchronised strobe is seen high.

Top module: `strobe_ram`

## Requirements
- R1: The address is captured when the strobe falls. An address change made after the fall does not change which word is read in that cycle.
- R2: In a cycle that began with the bank select high, nothing is written, even if the bank select then goes low. The output-enable flag stays low for that whole cycle.
- R3: In a selected read cycle, the output-enable flag is high and `dout` is 0 until the access latency ends. The latency is SYNC_STAGES+1+ACC_LAT clock edges after the strobe pin falls; the default is 6. From then on `dout` shows the addressed word.
- R4: When the strobe rises, `dout` freezes at the last word read. It stays there until the next fall, even if the address pins change.
- R5: Between cycles, the output-enable flag is high exactly when the primary select is low, the live bank select is low and the write control is high.
- R6: During a cycle, the output-enable flag follows the captured bank select. A change on the bank select pin after the fall does not change it.
- R7: While the write control is low, the output-enable flag is low, both inside and outside a cycle.
- R8: While the primary select is high, the output-enable flag is low.
- R9: A write to the captured address needs the strobe, the write control and the primary select all low in a selected cycle. Once the write control or the primary select rises, data changes that follow are not stored.
- R10: While the write window stays open, the addressed word may be rewritten any number of times. The last data present before the window closes is the one kept.
- R11: With the write control held low across several consecutive cycles, each cycle stores its own data at its own captured address.
- R12: After reset, the output-enable flag is low and `dout` is 0. Memory contents are not reset.
- R13: In one cycle the block can write a word and then, once the write control goes high, read that new word on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample and edge-detect all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_n | input | 1 | Cycle strobe, active low; its fall starts a cycle |
| wr_n | input | 1 | Write control, active low; also forces the output off |
| sel_n | input | 1 | Primary select, active low, not latched |
| bank_n | input | 1 | Bank select, active low; captured at the strobe fall |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data (held between cycles) |
| dout_oe | output | 1 | High when an external three-state driver should drive `dout` |

## Verification
If the captured address or the captured bank select is wrong, the damage shows up as a wrong word or a wrong enable flag. That happens at the first valid read, SYNC_STAGES+1+ACC_LAT edges after the fall. A wrong write gate does not show when it happens. It shows only later, when the bench reads back the affected word in a separate cycle, so every write scenario ends with a read-back of each word it touched. A mistake in the latency count or in the hold register shows up within one clock of the expected edge. The bench therefore samples `dout` on the cycle just before the data becomes valid and on the cycle when it does, and samples it again after the strobe rises.

// File: rtl/strobe_ram_pkg.sv
package strobe_ram_pkg;

    // Cycle controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // between cycles, outputs track live selects
        ST_WAIT  = 2'd1,   // selected cycle, access latency counting
        ST_VALID = 2'd2,   // selected cycle, read data valid
        ST_DESEL = 2'd3    // cycle started with bank select high
    } ram_state_t;

endpackage

// File: rtl/strobe_ram_sync.sv
// Multi-stage input sampling pipeline with a reset value per bit.
module strobe_ram_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/strobe_ram_ctrl.sv
// Cycle controller: strobe edge detection, address/bank capture,
// access latency count and write gating.
module strobe_ram_ctrl
    import strobe_ram_pkg::*;
#(
    parameter int AW      = 8,
    parameter int ACC_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_s,
    input  logic          w_s,
    input  logic          s1_s,
    input  logic          s2_s,
    input  logic [AW-1:0] a_s,
    output ram_state_t    state,
    output logic          fall,
    output logic [AW-1:0] addr_q,
    output logic          s2_q,
    output logic          we
);

    localparam int CNT_W = (ACC_LAT < 2) ? 1 : $clog2(ACC_LAT);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT - 1);

    ram_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             e_d;

    assign fall  = e_d & ~e_s;
    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            e_d     <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            e_d     <= e_s;
        end
    end

    // capture registers for address and bank select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            s2_q   <= 1'b1;
        end else if (state_q == ST_IDLE && fall) begin
            addr_q <= a_s;
            s2_q   <= s2_s;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d = s2_s ? ST_DESEL : ST_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_WAIT: begin
                if (e_s)                state_d = ST_IDLE;
                else if (cnt_q == '0)   state_d = ST_VALID;
                else                    cnt_d   = cnt_q - 1'b1;
            end
            ST_VALID: begin
                if (e_s) state_d = ST_IDLE;
            end
            ST_DESEL: begin
                if (e_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        we = 1'b0;
        unique case (state_q)
            ST_WAIT, ST_VALID: we = ~e_s & ~w_s & ~s1_s;
            ST_IDLE, ST_DESEL: we = 1'b0;
            default:           we = 1'b0;
        endcase
    end

endmodule

// File: rtl/strobe_ram_array.sv
// Word storage, one write port and one asynchronous read port, no reset.
module strobe_ram_array #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd = mem[ra];

endmodule

// File: rtl/strobe_ram_out.sv
// Read data hold register and output-enable generation.
module strobe_ram_out
    import strobe_ram_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ram_state_t    state,
    input  logic          fall,
    input  logic          e_s,
    input  logic          w_s,
    input  logic          s1_s,
    input  logic          s2_s,
    input  logic          s2_q,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);

    logic [DW-1:0] hold_q;
    logic          live;
    logic          bank_on;

    assign live = (state == ST_VALID) & ~e_s & ~s1_s & w_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          hold_q <= '0;
        else if (state == ST_IDLE && fall)   hold_q <= '0;
        else if (live)                       hold_q <= rd_data;
    end

    always_comb begin
        bank_on = 1'b0;
        unique case (state)
            ST_IDLE:                     bank_on = ~s2_s;
            ST_WAIT, ST_VALID, ST_DESEL: bank_on = ~s2_q;
            default:                     bank_on = 1'b0;
        endcase
    end

    assign dout    = live ? rd_data : hold_q;
    assign dout_oe = bank_on & ~s1_s & w_s;

endmodule

// File: rtl/strobe_ram.sv
// Top level: input sampling, controller, storage and output stage.
module strobe_ram
    import strobe_ram_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ACC_LAT     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_n,
    input  logic          wr_n,
    input  logic          sel_n,
    input  logic          bank_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);

    logic          e_s, w_s, s1_s, s2_s;
    logic [AW-1:0] a_s;
    logic [DW-1:0] d_s;
    logic [3:0]    ctl_s;
    ram_state_t    state;
    logic          fall;
    logic [AW-1:0] addr_q;
    logic          s2_q;
    logic          we;
    logic [DW-1:0] rd_data;

    strobe_ram_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({cyc_n, wr_n, sel_n, bank_n}), .q(ctl_s)
    );

    strobe_ram_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(a_s)
    );

    strobe_ram_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(din), .q(d_s)
    );

    assign {e_s, w_s, s1_s, s2_s} = ctl_s;

    strobe_ram_ctrl #(.AW(AW), .ACC_LAT(ACC_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .e_s(e_s), .w_s(w_s), .s1_s(s1_s), .s2_s(s2_s), .a_s(a_s),
        .state(state), .fall(fall), .addr_q(addr_q), .s2_q(s2_q), .we(we)
    );

    strobe_ram_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .we(we), .wa(addr_q), .wd(d_s), .ra(addr_q), .rd(rd_data)
    );

    strobe_ram_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .fall(fall),
        .e_s(e_s), .w_s(w_s), .s1_s(s1_s), .s2_s(s2_s), .s2_q(s2_q),
        .rd_data(rd_data), .dout(dout), .dout_oe(dout_oe)
    );

endmodule

// File: rtl/strobe_ram_chk.sv
// Property checker attached to the top module.
module strobe_ram_chk
    import strobe_ram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input ram_state_t    state,
    input logic          fall,
    input logic          e_s,
    input logic          w_s,
    input logic          s1_s,
    input logic [AW-1:0] a_s,
    input logic [AW-1:0] addr_q,
    input logic          s2_q,
    input logic          we,
    input logic [DW-1:0] dout,
    input logic          dout_oe
);

    assert_fall_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fall) |=> (addr_q == $past(a_s)));

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESEL) |-> (!we && !dout_oe));

    assert_wait_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (dout == '0));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(dout));

    assert_wr_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !w_s |-> !dout_oe);

    assert_s1_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_s |-> !dout_oe);

    assert_we_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (!e_s && !w_s && !s1_s && !s2_q));

endmodule

bind strobe_ram strobe_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .fall(fall),
    .e_s(e_s), .w_s(w_s), .s1_s(s1_s), .a_s(a_s),
    .addr_q(addr_q), .s2_q(s2_q), .we(we),
    .dout(dout), .dout_oe(dout_oe)
);

// File: tb/strobe_ram_bench.sv
module strobe_ram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 4;
    localparam int SYNC_STAGES = 2;
    localparam int ACC_LAT = 3;
    localparam int LAT_EDGES = SYNC_STAGES + 1 + ACC_LAT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          sel_n = 1'b1;
    logic          bank_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_ram #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES), .ACC_LAT(ACC_LAT)) u_strobe_ram (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .wr_n(wr_n), .sel_n(sel_n),
        .bank_n(bank_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic end_cycle();
        cyc_n = 1'b1; wr_n = 1'b1; sel_n = 1'b1;
        step(4);
    endtask

    task automatic write_cycle(input logic [7:0] a, input logic [3:0] d);
        addr = a; din = d; bank_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(10);
        end_cycle();
        model[a] = d;
    endtask

    // read with latency, freeze and between-cycle enable checks (R3, R4, R5)
    task automatic read_cycle(input logic [7:0] a);
        addr = a; wr_n = 1'b1; sel_n = 1'b0; bank_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(LAT_EDGES - 1);
        check("R3 dout before latency", {4'h0, dout}, 8'h00);
        check("R3 oe before latency", {7'h0, dout_oe}, 8'h01);
        step(1);
        check("R3 dout at latency", {4'h0, dout}, {4'h0, model[a]});
        step(2);
        cyc_n = 1'b1;
        step(1);
        addr = ~a;
        step(4);
        check("R4 dout frozen", {4'h0, dout}, {4'h0, model[a]});
        check("R5 oe between cycles", {7'h0, dout_oe}, 8'h01);
        sel_n = 1'b1;
        step(3);
    endtask

    task automatic t_reset();
        step(3);
        check("R12 oe in reset", {7'h0, dout_oe}, 8'h00);
        check("R12 dout in reset", {4'h0, dout}, 8'h00);
        rst_n = 1'b1;
        step(4);
        check("R12 oe after reset", {7'h0, dout_oe}, 8'h00);
        check("R12 dout after reset", {4'h0, dout}, 8'h00);
    endtask

    task automatic t_basic();
        write_cycle(8'h00, 4'hA);
        write_cycle(8'hFF, 4'h5);
        write_cycle(8'h5A, 4'h3);
        write_cycle(8'h33, 4'hC);
        read_cycle(8'h00);
        read_cycle(8'hFF);
        read_cycle(8'h5A);
        read_cycle(8'h33);
    endtask

    task automatic t_capture();
        addr = 8'h5A; wr_n = 1'b1; sel_n = 1'b0; bank_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(3);
        addr = 8'hFF; bank_n = 1'b1;
        step(LAT_EDGES - 3);
        check("R1 address held", {4'h0, dout}, {4'h0, model[8'h5A]});
        check("R6 captured bank", {7'h0, dout_oe}, 8'h01);
        cyc_n = 1'b1;
        step(4);
        check("R5 live bank high", {7'h0, dout_oe}, 8'h00);
        bank_n = 1'b0;
        step(3);
        check("R5 live bank low", {7'h0, dout_oe}, 8'h01);
        wr_n = 1'b0;
        step(3);
        check("R7 oe idle wr low", {7'h0, dout_oe}, 8'h00);
        wr_n = 1'b1;
        step(3);
        check("R5 oe restored", {7'h0, dout_oe}, 8'h01);
        sel_n = 1'b1;
        step(3);
        check("R8 oe sel high", {7'h0, dout_oe}, 8'h00);
    endtask

    task automatic t_desel();
        addr = 8'h33; din = 4'h1; bank_n = 1'b1; sel_n = 1'b0; wr_n = 1'b1;
        step(1);
        cyc_n = 1'b0;
        step(3);
        bank_n = 1'b0;
        step(5);
        check("R2 oe in deselected cycle", {7'h0, dout_oe}, 8'h00);
        wr_n = 1'b0;
        step(6);
        end_cycle();
        read_cycle(8'h33);
    endtask

    task automatic t_end_write();
        addr = 8'h21; din = 4'h6; bank_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(8);
        wr_n = 1'b1;
        step(1);
        din = 4'h9;
        step(6);
        end_cycle();
        model[8'h21] = 4'h6;
        addr = 8'h22; din = 4'h7; sel_n = 1'b0; wr_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(8);
        sel_n = 1'b1;
        step(1);
        din = 4'hE;
        step(6);
        end_cycle();
        model[8'h22] = 4'h7;
        read_cycle(8'h21);
        check("R9 write ends on wr rise", {4'h0, dout}, 8'h06);
        read_cycle(8'h22);
        check("R9 write ends on sel rise", {4'h0, dout}, 8'h07);
    endtask

    task automatic t_overwrite();
        addr = 8'h44; din = 4'h1; bank_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(6);
        for (int i = 2; i < 5; i++) begin
            din = 4'(i * 3);
            step(3);
        end
        end_cycle();
        model[8'h44] = 4'hC;
        read_cycle(8'h44);
        check("R10 last data kept", {4'h0, dout}, 8'h0C);
    endtask

    task automatic t_consecutive();
        wr_n = 1'b0; sel_n = 1'b0; bank_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            addr = 8'(8'h10 + i); din = 4'(i ^ 5);
            step(1);
            cyc_n = 1'b0;
            step(8);
            cyc_n = 1'b1;
            step(4);
            model[8'h10 + i] = 4'(i ^ 5);
        end
        wr_n = 1'b1; sel_n = 1'b1;
        step(4);
        for (int i = 0; i < 4; i++) begin
            read_cycle(8'(8'h10 + i));
            check("R11 consecutive write", {4'h0, dout}, {4'h0, 4'(i ^ 5)});
        end
    endtask

    task automatic t_read_write();
        addr = 8'h77; din = 4'hB; bank_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
        step(1);
        cyc_n = 1'b0;
        step(7);
        check("R7 oe in cycle wr low", {7'h0, dout_oe}, 8'h00);
        wr_n = 1'b1;
        step(3);
        check("R13 new word read", {4'h0, dout}, 8'h0B);
        check("R13 oe after write", {7'h0, dout_oe}, 8'h01);
        end_cycle();
        model[8'h77] = 4'hB;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_capture();
        t_desel();
        t_end_write();
        t_overwrite();
        t_consecutive();
        t_read_write();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule